// File: doc/BRIEF.md
# Oversampling Sample Averager and Output Formatter

This block sits between a converter that delivers raw 12-bit samples and the register that holds the converted value. A start request captures three settings: an averaging code, a latency select and an output format. The block then counts a settling interval in converter clock-enable pulses, discarding any samples that arrive during it. After that it accumulates a power-of-two number of valid samples and divides the sum by the count with a right shift. The mean goes out either as offset binary or as two's complement. When the result is ready, a one-cycle completion pulse is raised and the result is held.

The analog front end and the software-visible registers lie outside this block. Software-side logic raises `start_i` and waits for `done_o`, or polls `busy_o`. `result_o` keeps its value until the next completion.

Top module: `ovs_mean_unit`

## Requirements
- R1: The averaging code selects 2^code accepted samples per result for codes 0 to 6 (1, 2, 4, 8, 16, 32, 64). Code 7 behaves exactly like code 6.
- R2: The result is the integer sum of the accepted samples divided by their count, rounded down. An all-0xFFF input yields 0xFFF in offset-binary format.
- R3: With `fast_lat_i`=0 the settling interval lasts 40 clock-enable pulses after the start edge. With `fast_lat_i`=1 it lasts 20. A valid sample presented on or before the edge that carries the last settling pulse is discarded.
- R4: The settling interval advances only on clock edges where `adc_ce_i` is high. Sparse enables stretch it in proportion.
- R5: With `fmt_offset_i`=1 the result is the offset-binary mean. With `fmt_offset_i`=0 it is the same mean with bit 11 inverted (two's complement).
- R6: `busy_o` rises on the edge that accepts a start and falls on the edge where `done_o` rises. `done_o` is high for exactly one cycle, on the edge after the last accepted sample.
- R7: A start request while `busy_o` is high is ignored. Changes of the code, latency select or format inputs during a run have no effect on that run.
- R8: After reset, `busy_o`=0, `done_o`=0 and `result_o`=0x000.
- R9: `result_o` changes only on the edge that raises `done_o`.
- R10: Samples with `smp_valid_i` low are not accumulated. Samples presented while idle are not accumulated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a new averaged conversion |
| avg_code_i | input | 3 | Averaging code, 2^code samples (7 treated as 6) |
| fast_lat_i | input | 1 | Settling select: 1 = 20 enables, 0 = 40 enables |
| fmt_offset_i | input | 1 | Output format: 1 = offset binary, 0 = two's complement |
| adc_ce_i | input | 1 | Converter clock enable, paces the settling interval |
| smp_valid_i | input | 1 | Raw sample strobe |
| smp_data_i | input | 12 | Raw sample value |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Averaged, formatted result |

## Verification
A settling counter with the wrong target, or one that ignores the enable, makes `done_o` arrive on the wrong edge. It also makes the mean include or drop samples at the window boundary. Both show up on the first completion after start, so the bench predicts the exact completion edge as well as the value. A sample counter or accumulator that is off by one, or that fails to clear, corrupts the very next result. A wrong shift or format bit shows up as a factor-of-two error or a flipped bit 11. Sample streams and constant extremes are chosen so that each of these faults gives a distinct value.

// File: rtl/ovs_pkg.sv
`timescale 1ns/1ps
// Shared defaults and types for the oversampling averager.
// Assumes samples are unsigned offset-binary words from the converter.
package ovs_pkg;
    localparam int OVS_SMP_W    = 12;  // raw sample width
    localparam int OVS_MAX_CODE = 6;   // largest averaging code (64 samples)
    localparam int OVS_LAT_SLOW = 40;  // settling enables, slow select
    localparam int OVS_LAT_FAST = 20;  // settling enables, fast select

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_COLLECT = 2'd2,
        ST_DONE    = 2'd3
    } ovs_state_e;
endpackage

// File: rtl/ovs_settle_timer.sv
`timescale 1ns/1ps
// Counts converter clock-enable pulses while settling and flags the pulse
// that ends the interval. Assumes fast_i is held stable while run_i is high.
module ovs_settle_timer #(
    parameter int LAT_SLOW = 40,
    parameter int LAT_FAST = 20,
    localparam int LAT_W   = $clog2(LAT_SLOW + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic ce_i,
    input  logic fast_i,
    output logic expire_o
);
    logic [LAT_W-1:0] cnt_q;
    logic [LAT_W-1:0] target;

    // Index of the final settling pulse for the selected latency.
    always_comb begin
        target = fast_i ? LAT_W'(LAT_FAST - 1) : LAT_W'(LAT_SLOW - 1);
    end

    assign expire_o = run_i & ce_i & (cnt_q == target);

    // Pulse counter: cleared on a new start, advanced by each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clear_i)        cnt_q <= '0;
        else if (run_i && ce_i)  cnt_q <= cnt_q + 1'b1;
    end

    // R3
    settle_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= target));
endmodule

// File: rtl/ovs_accum.sv
`timescale 1ns/1ps
// Sums accepted samples and counts them against the 2^code goal.
// Assumes code_i is already clamped to MAX_CODE and held during a run.
module ovs_accum #(
    parameter int SMP_W    = 12,
    parameter int MAX_CODE = 6,
    localparam int CODE_W  = $clog2(MAX_CODE + 1),
    localparam int ACC_W   = SMP_W + MAX_CODE,
    localparam int CNT_W   = MAX_CODE + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              add_i,
    input  logic [SMP_W-1:0]  sample_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              last_o
);
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] goal;

    // Number of samples required for the current code.
    always_comb begin
        goal = CNT_W'(1) << code_i;
    end

    assign last_o = add_i & (cnt_q == goal - 1'b1);
    assign acc_o  = acc_q;

    // Running sum and sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add_i) begin
            acc_q <= acc_q + ACC_W'(sample_i);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= goal);
    // R2
    acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= ACC_W'(cnt_q) * ACC_W'((1 << SMP_W) - 1));
endmodule

// File: rtl/ovs_format.sv
`timescale 1ns/1ps
// Divides the sum by 2^code with a shift and applies the output format.
// Purely combinational; assumes the sum never exceeds 2^code full-scale samples.
module ovs_format #(
    parameter int SMP_W    = 12,
    parameter int MAX_CODE = 6,
    localparam int CODE_W  = $clog2(MAX_CODE + 1),
    localparam int ACC_W   = SMP_W + MAX_CODE
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              offset_i,
    output logic [SMP_W-1:0]  word_o
);
    logic [SMP_W-1:0] cand [MAX_CODE+1];
    logic [SMP_W-1:0] mean;

    // One shifted view of the sum per supported code.
    for (genvar c = 0; c <= MAX_CODE; c++) begin : g_shift
        assign cand[c] = acc_i[c +: SMP_W];
    end

    // Pick the view that matches the code.
    always_comb begin
        mean = cand[0];
        for (int c = 0; c <= MAX_CODE; c++) begin
            if (code_i == CODE_W'(c)) mean = cand[c];
        end
    end

    // Two's complement is the offset-binary mean with its top bit flipped.
    always_comb begin
        word_o = offset_i ? mean : {~mean[SMP_W-1], mean[SMP_W-2:0]};
    end
endmodule

// File: rtl/ovs_mean_unit.sv
`timescale 1ns/1ps
// Oversampling averager: settle, collect 2^code samples, shift, format.
// Assumes the sample source holds data valid for one clock per strobe.
module ovs_mean_unit
    import ovs_pkg::*;
#(
    parameter int SMP_W    = OVS_SMP_W,
    parameter int MAX_CODE = OVS_MAX_CODE,
    parameter int LAT_SLOW = OVS_LAT_SLOW,
    parameter int LAT_FAST = OVS_LAT_FAST,
    localparam int CODE_W  = $clog2(MAX_CODE + 1),
    localparam int ACC_W   = SMP_W + MAX_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] avg_code_i,
    input  logic              fast_lat_i,
    input  logic              fmt_offset_i,
    input  logic              adc_ce_i,
    input  logic              smp_valid_i,
    input  logic [SMP_W-1:0]  smp_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [SMP_W-1:0]  result_o
);
    ovs_state_e        state_q;
    logic [CODE_W-1:0] code_q;
    logic              fast_q;
    logic              offset_q;
    logic [SMP_W-1:0]  result_q;
    logic              done_q;
    logic              accept;
    logic              expire;
    logic              last;
    logic [ACC_W-1:0]  acc;
    logic [SMP_W-1:0]  word;
    logic [CODE_W-1:0] code_eff;

    assign accept = start_i && (state_q == ST_IDLE);

    // Clamp codes above the largest supported one.
    always_comb begin
        code_eff = (avg_code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : avg_code_i;
    end

    // Capture the run settings when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            fast_q   <= 1'b0;
            offset_q <= 1'b1;
        end else if (accept) begin
            code_q   <= code_eff;
            fast_q   <= fast_lat_i;
            offset_q <= fmt_offset_i;
        end
    end

    // Sequencer: idle, settle, collect, then one finishing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (accept) state_q <= ST_SETTLE;
                ST_SETTLE:  if (expire) state_q <= ST_COLLECT;
                ST_COLLECT: if (last)   state_q <= ST_DONE;
                ST_DONE:                state_q <= ST_IDLE;
                default:                state_q <= ST_IDLE;
            endcase
        end
    end

    // Register the formatted mean and the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (state_q == ST_DONE);
            if (state_q == ST_DONE) result_q <= word;
        end
    end

    ovs_settle_timer #(
        .LAT_SLOW (LAT_SLOW),
        .LAT_FAST (LAT_FAST)
    ) settle_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .run_i    (state_q == ST_SETTLE),
        .ce_i     (adc_ce_i),
        .fast_i   (fast_q),
        .expire_o (expire)
    );

    ovs_accum #(
        .SMP_W    (SMP_W),
        .MAX_CODE (MAX_CODE)
    ) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (accept),
        .add_i    ((state_q == ST_COLLECT) && smp_valid_i),
        .sample_i (smp_data_i),
        .code_i   (code_q),
        .acc_o    (acc),
        .last_o   (last)
    );

    ovs_format #(
        .SMP_W    (SMP_W),
        .MAX_CODE (MAX_CODE)
    ) format_i (
        .acc_i    (acc),
        .code_i   (code_q),
        .offset_i (offset_q),
        .word_o   (word)
    );

    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = result_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));
    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));
    // R4
    settle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLLECT && $past(state_q) == ST_SETTLE) |-> $past(adc_ce_i));
    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SETTLE && $past(state_q) != ST_SETTLE) |-> $past(state_q) == ST_IDLE);
endmodule

// File: tb/ovs_mean_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for the oversampling averager.
module ovs_mean_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  avg_code_i = '0;
    logic        fast_lat_i = 1'b0;
    logic        fmt_offset_i = 1'b1;
    logic        adc_ce_i = 1'b1;
    logic        smp_valid_i = 1'b0;
    logic [11:0] smp_data_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [11:0] result_o;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ovs_mean_unit dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .avg_code_i   (avg_code_i),
        .fast_lat_i   (fast_lat_i),
        .fmt_offset_i (fmt_offset_i),
        .adc_ce_i     (adc_ce_i),
        .smp_valid_i  (smp_valid_i),
        .smp_data_i   (smp_data_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .result_o     (result_o)
    );

    task automatic chk(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int smp_val(int k, int base, int konst);
        if (konst >= 0) return konst;
        return (base + k * k * 37 + k * 151) % 4096;
    endfunction

    // One averaged conversion; vs/cs = valid/enable strides, poke = restart attempts.
    task automatic conv(string tag, int code, int fast, int fmt, int vs, int cs,
                        int konst, int base, int poke1, int poke2, int junk);
        int eff = (code > 6) ? 6 : code;
        int m = 1 << eff;
        int lat = fast ? 20 : 40;
        int ces = 0, n = 0, sum = 0, done_k = -1, phase = 0;
        int seen_k = -1;
        int expv;
        bit busy_bad = 0;
        logic [11:0] held;
        // Model from R1-style rules: settle on enables, then collect valid samples.
        for (int k = 1; k < 5000; k++) begin
            if (phase == 0) begin
                if (k % cs == 0) begin
                    ces++;
                    if (ces == lat) phase = 1;
                end
            end else if (k % vs == 0) begin
                sum += smp_val(k, base, konst);
                n++;
                if (n == m) begin
                    done_k = k + 1;
                    break;
                end
            end
        end
        expv = sum >> eff;
        if (fmt == 0) expv = expv ^ 12'h800;

        if (junk != 0) begin
            held = result_o;
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                smp_valid_i = 1'b1; smp_data_i = 12'hFFF; adc_ce_i = 1'b1;
            end
            @(negedge clk);
            chk(!done_o && !busy_o && result_o == held, {tag, " R10 idle samples ignored"},
                int'(result_o), int'(held));
        end

        @(negedge clk);
        avg_code_i = 3'(code); fast_lat_i = fast[0]; fmt_offset_i = fmt[0];
        start_i = 1'b1; smp_valid_i = 1'b0; adc_ce_i = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b1, {tag, " R6 busy after start"}, int'(busy_o), 1);
        for (int k = 1; k < done_k + 6; k++) begin
            if (k == poke1 || k == poke2) begin
                start_i = 1'b1;
                avg_code_i = 3'(7 - code); fast_lat_i = !fast[0]; fmt_offset_i = !fmt[0];
            end else begin
                start_i = 1'b0;
            end
            adc_ce_i    = (k % cs == 0);
            smp_valid_i = (k % vs == 0);
            smp_data_i  = 12'(smp_val(k, base, konst));
            @(negedge clk);
            if (done_o) begin
                seen_k = k;
                break;
            end
            if (!busy_o) busy_bad = 1;
        end
        start_i = 1'b0;
        chk(!busy_bad, {tag, " R6 busy held during run"}, int'(busy_bad), 0);
        chk(seen_k == done_k, {tag, " R3 R4 R7 completion edge"}, seen_k, done_k);
        chk(result_o == 12'(expv), {tag, " R1 R2 R5 R10 result"}, int'(result_o), expv);
        chk(busy_o == 1'b0, {tag, " R6 busy low at done"}, int'(busy_o), 0);
        held = result_o;
        smp_valid_i = 1'b1; smp_data_i = 12'h123;
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R6 done single cycle"}, int'(done_o), 0);
        chk(result_o == held, {tag, " R9 result held"}, int'(result_o), int'(held));
        smp_valid_i = 1'b0; adc_ce_i = 1'b1;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0, "R8 busy after reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R8 done after reset", int'(done_o), 0);
        chk(result_o == 12'h000, "R8 result after reset", int'(result_o), 0);
    endtask

    initial begin
        t_reset();
        conv("single",   0, 1, 1, 1, 1, -1,  5, -1, -1, 1);
        conv("eight",    3, 0, 1, 1, 1, -1, 99, -1, -1, 0);
        conv("max64",    6, 1, 0, 1, 1, -1, 17, -1, -1, 0);
        conv("code7",    7, 1, 1, 1, 1, -1, 41, -1, -1, 0);
        conv("sparse_v", 2, 1, 1, 3, 1, -1,  7, -1, -1, 0);
        conv("sparse_ce",1, 0, 0, 1, 3, -1, 63, -1, -1, 0);
        conv("restart",  4, 0, 1, 1, 1, -1, 11, 10, 45, 0);
        conv("fullscale",6, 0, 1, 1, 1, 4095, 0, -1, -1, 0);
        conv("fs_twos",  5, 1, 0, 1, 1, 4095, 0, -1, -1, 0);
        conv("zero_twos",2, 1, 0, 1, 1, 0,    0, -1, -1, 1);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule